// File: doc/BRIEF.md
# Multiplexed Upper Address Latch Sequencer

This block orders the address phases of one external bus access on a 20-pin address group. A request carries a byte address, a bus width code and a channel size code. The block aligns the byte address to the bus width and splits it into an 8-bit upper field and a 20-bit lower field. It then decides whether an upper-address phase is needed. That phase drives the upper field on the top eight pins and pulses an enable strobe, so that an external latch can capture it. An optional hold cycle may follow. The block then drives the lower field and pulses a ready signal that opens the data phase.

The upper phase costs at least one bus cycle. It is skipped when the latch already holds the same upper value, or when the channel is too small for the bus width to need upper bits. The first access after reset is the exception and always runs it.

The controller is a four-state machine:
- `ST_IDLE`: waits for a request.
- `ST_UPPER`: drives the upper field and the strobe.
- `ST_HOLD`: keeps the upper field on the pins for one more cycle.
- `ST_LOWER`: drives the lower field and the ready pulse.

Its transitions are:
- `ST_IDLE`→`ST_UPPER` when a request needs an upper phase.
- `ST_IDLE`→`ST_LOWER` when it does not.
- `ST_UPPER`→`ST_HOLD` when hold is enabled.
- `ST_UPPER`→`ST_LOWER` when hold is disabled.
- `ST_HOLD`→`ST_LOWER` always.
- `ST_LOWER`→`ST_IDLE` always.

Top module: `upal_ctrl`

## Requirements
- R1: After reset, `addr_pins` is zero, and `ua_strobe`, `lo_ready` and `req_taken` are low while no request is offered.
- R2: The byte address is shifted right by the width code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit; code 3 acts as 2). In the upper phase, shifted bits [27:20] appear on `addr_pins[19:12]` and `addr_pins[11:0]` is zero. In the lower phase, shifted bits [19:0] appear on `addr_pins`.
- R3: The first request accepted after reset always runs an upper phase, whatever its size and width codes.
- R4: A later request runs an upper phase only when both of these hold: its size code (0 = 1 MB, 1 = 2 MB, 2 = 4 MB, 3 = 8 MB or more) is greater than its effective width code, and its upper field differs from the last upper field sent.
- R5: The last-sent upper value changes only when an upper phase runs. A request skipped for a small channel does not change it.
- R6: With `hold_en` high during the strobe cycle, the next cycle keeps `addr_pins` unchanged with the strobe and ready low. With `hold_en` low, the lower phase follows the strobe cycle directly.
- R7: `ua_strobe` is a single-cycle pulse.
- R8: `req_taken` is high only in an idle cycle in which `req_valid` is high. `lo_ready` is a single-cycle pulse. No request is taken between a take and its ready pulse.
- R9: If a request is taken in cycle T, the first cycle after T carries the strobe when an upper phase runs, and the lower phase otherwise. The lower phase comes at T+1, T+2 or T+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_en | input | 1 | Adds the hold cycle after the strobe; applies to all channels |
| req_valid | input | 1 | Request offered |
| req_addr | input | 30 | Byte address of the access |
| req_width | input | 2 | Bus width code |
| req_size | input | 2 | Channel size code, log2 of megabytes |
| req_taken | output | 1 | Request accepted this cycle |
| addr_pins | output | 20 | Multiplexed address pins |
| ua_strobe | output | 1 | Upper-address enable pulse |
| lo_ready | output | 1 | Lower address driven; data phase may start |

## Verification
The bench builds the block with its default widths: a 30-bit byte address, 20 address pins and an 8-bit upper field. With these widths, every alignment shift can push distinct bits into the upper field, so every width code reaches both the skip outcome and the strobe outcome. The size codes cover all four channel sizes. Together they reach every cell of the width-by-size table. A reset in mid-run makes the forced first upper phase reachable a second time.

// File: rtl/upal_pkg.sv
package upal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_UPPER = 2'd1,
        ST_HOLD  = 2'd2,
        ST_LOWER = 2'd3
    } upal_state_e;

    localparam int WCODE_W = 2;
    localparam int SIZE_W  = 2;

    // Effective shift for a width code: 3 is treated like the 32-bit code.
    function automatic logic [WCODE_W-1:0] eff_shift(input logic [WCODE_W-1:0] wcode);
        return (wcode == 2'd3) ? 2'd2 : wcode;
    endfunction

endpackage

// File: rtl/upal_align.sv
module upal_align
    import upal_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int PIN_W  = 20,
    parameter int UP_W   = 8
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WCODE_W-1:0] wcode,
    input  logic [SIZE_W-1:0]  size,
    output logic [UP_W-1:0]    up_field,
    output logic [PIN_W-1:0]   lo_field,
    output logic               size_ok
);

    localparam int SPLIT_W = PIN_W + UP_W;
    localparam int EXT_W   = (ADDR_W > SPLIT_W) ? ADDR_W : SPLIT_W;

    logic [EXT_W-1:0]   ext_addr;
    logic [EXT_W-1:0]   shifted;
    logic [WCODE_W-1:0] sh;

    always_comb begin
        sh       = eff_shift(wcode);
        ext_addr = EXT_W'(addr);
        shifted  = ext_addr >> sh;
    end

    assign up_field = shifted[SPLIT_W-1:PIN_W];
    assign lo_field = shifted[PIN_W-1:0];

    // The channel uses upper bits only when its size code exceeds the shift.
    assign size_ok  = (SIZE_W'(sh) < size);

    generate
        if (EXT_W > SPLIT_W) begin : g_drop_hi
            logic unused_hi;
            assign unused_hi = ^shifted[EXT_W-1:SPLIT_W];
        end
    endgenerate

endmodule

// File: rtl/upal_track.sv
module upal_track #(
    parameter int UP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [UP_W-1:0] cand_up,
    input  logic            size_ok,
    input  logic            commit,
    input  logic [UP_W-1:0] commit_up,
    output logic            need_upper
);

    logic [UP_W-1:0] last_up;
    logic            first_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_up    <= '0;
            first_pend <= 1'b1;
        end else if (commit) begin
            last_up    <= commit_up;
            first_pend <= 1'b0;
        end
    end

    assign need_upper = first_pend || (size_ok && (cand_up != last_up));

endmodule

// File: rtl/upal_fsm.sv
module upal_fsm
    import upal_pkg::*;
#(
    parameter int PIN_W = 20,
    parameter int UP_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             hold_en,
    input  logic             need_upper,
    input  logic [UP_W-1:0]  up_field,
    input  logic [PIN_W-1:0] lo_field,
    output logic             req_taken,
    output logic [PIN_W-1:0] addr_pins,
    output logic             ua_strobe,
    output logic             lo_ready,
    output logic             commit,
    output logic [UP_W-1:0]  commit_up
);

    localparam int LOW_PAD = PIN_W - UP_W;

    upal_state_e     state, state_nx;
    logic [UP_W-1:0]  up_q;
    logic [PIN_W-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q <= '0;
            lo_q <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            up_q <= up_field;
            lo_q <= lo_field;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = need_upper ? ST_UPPER : ST_LOWER;
            ST_UPPER: state_nx = hold_en ? ST_HOLD : ST_LOWER;
            ST_HOLD:  state_nx = ST_LOWER;
            ST_LOWER: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        req_taken = 1'b0;
        addr_pins = '0;
        ua_strobe = 1'b0;
        lo_ready  = 1'b0;
        commit    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_taken = req_valid;
            end
            ST_UPPER: begin
                addr_pins = {up_q, {LOW_PAD{1'b0}}};
                ua_strobe = 1'b1;
                commit    = 1'b1;
            end
            ST_HOLD: begin
                addr_pins = {up_q, {LOW_PAD{1'b0}}};
            end
            ST_LOWER: begin
                addr_pins = lo_q;
                lo_ready  = 1'b1;
            end
        endcase
    end

    assign commit_up = up_q;

endmodule

// File: rtl/upal_ctrl.sv
module upal_ctrl
    import upal_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int PIN_W  = 20,
    parameter int UP_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_width,
    input  logic [1:0]        req_size,
    output logic              req_taken,
    output logic [PIN_W-1:0]  addr_pins,
    output logic              ua_strobe,
    output logic              lo_ready
);

    logic [UP_W-1:0]  up_field;
    logic [PIN_W-1:0] lo_field;
    logic             size_ok;
    logic             need_upper;
    logic             commit;
    logic [UP_W-1:0]  commit_up;

    upal_align #(.ADDR_W(ADDR_W), .PIN_W(PIN_W), .UP_W(UP_W)) u_align (
        .addr     (req_addr),
        .wcode    (req_width),
        .size     (req_size),
        .up_field (up_field),
        .lo_field (lo_field),
        .size_ok  (size_ok)
    );

    upal_track #(.UP_W(UP_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_up    (up_field),
        .size_ok    (size_ok),
        .commit     (commit),
        .commit_up  (commit_up),
        .need_upper (need_upper)
    );

    upal_fsm #(.PIN_W(PIN_W), .UP_W(UP_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .hold_en    (hold_en),
        .need_upper (need_upper),
        .up_field   (up_field),
        .lo_field   (lo_field),
        .req_taken  (req_taken),
        .addr_pins  (addr_pins),
        .ua_strobe  (ua_strobe),
        .lo_ready   (lo_ready),
        .commit     (commit),
        .commit_up  (commit_up)
    );

endmodule

// File: rtl/upal_checker.sv
module upal_checker #(
    parameter int PIN_W = 20,
    parameter int UP_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hold_en,
    input logic             req_taken,
    input logic [PIN_W-1:0] addr_pins,
    input logic             ua_strobe,
    input logic             lo_ready
);

    logic inflight;
    logic strobe_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inflight    <= 1'b0;
            strobe_seen <= 1'b0;
        end else begin
            if (req_taken) inflight <= 1'b1;
            else if (lo_ready) inflight <= 1'b0;
            if (ua_strobe) strobe_seen <= 1'b1;
        end
    end

    assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ua_strobe |=> !ua_strobe);

    assert_hold_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ua_strobe && hold_en) |=> (!lo_ready && !ua_strobe && $stable(addr_pins)));

    assert_no_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ua_strobe && !hold_en) |=> lo_ready);

    assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lo_ready |=> !lo_ready);

    assert_single_inflight_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_taken |-> !inflight);

    assert_first_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lo_ready |-> strobe_seen);

    assert_upper_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ua_strobe |-> (addr_pins[PIN_W-UP_W-1:0] == '0));

    assert_phase_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_taken |=> (ua_strobe || lo_ready));

endmodule

bind upal_ctrl upal_checker #(.PIN_W(PIN_W), .UP_W(UP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_en   (hold_en),
    .req_taken (req_taken),
    .addr_pins (addr_pins),
    .ua_strobe (ua_strobe),
    .lo_ready  (lo_ready)
);

// File: tb/upal_ctrl_tb.sv
module upal_ctrl_tb;

    localparam int ADDR_W = 30;
    localparam int PIN_W  = 20;
    localparam int UP_W   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hold_en = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_width = '0;
    logic [1:0]        req_size = '0;
    logic              req_taken;
    logic [PIN_W-1:0]  addr_pins;
    logic              ua_strobe;
    logic              lo_ready;

    always #4 clk = ~clk;

    upal_ctrl #(.ADDR_W(ADDR_W), .PIN_W(PIN_W), .UP_W(UP_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_en   (hold_en),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_width (req_width),
        .req_size  (req_size),
        .req_taken (req_taken),
        .addr_pins (addr_pins),
        .ua_strobe (ua_strobe),
        .lo_ready  (lo_ready)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Expected per-cycle outputs, filled by the request model.
    bit               q_taken[$];
    logic [PIN_W-1:0] q_pins[$];
    bit               q_stb[$];
    bit               q_rdy[$];
    string            q_tag[$];

    bit         m_first;
    logic [7:0] m_last;

    task automatic push(input bit t, input logic [PIN_W-1:0] p, input bit s, input bit r, input string tag);
        q_taken.push_back(t);
        q_pins.push_back(p);
        q_stb.push_back(s);
        q_rdy.push_back(r);
        q_tag.push_back(tag);
    endtask

    // Monitor: compare every cycle at the falling edge.
    always @(negedge clk) begin
        bit               et, es, er;
        logic [PIN_W-1:0] ep;
        string            tg;
        if (!done) begin
            if (q_pins.size() > 0) begin
                et = q_taken.pop_front();
                ep = q_pins.pop_front();
                es = q_stb.pop_front();
                er = q_rdy.pop_front();
                tg = q_tag.pop_front();
            end else begin
                et = 1'b0; ep = '0; es = 1'b0; er = 1'b0;
                tg = "R1 R8 idle";
            end
            checks++;
            if (req_taken !== et || addr_pins !== ep || ua_strobe !== es || lo_ready !== er) begin
                fails++;
                $display("FAIL %s: taken/pins/stb/rdy actual %b/%h/%b/%b expected %b/%h/%b/%b",
                         tg, req_taken, addr_pins, ua_strobe, lo_ready, et, ep, es, er);
            end
        end
    end

    // Issue one request; called just after a rising edge, returns just after one.
    task automatic issue(input logic [ADDR_W-1:0] a, input int w, input int sz, input bit hold);
        int          s;
        int          phases;
        logic [31:0] sh;
        logic [7:0]  up;
        logic [19:0] lo;
        bit          need;
        s    = (w == 3) ? 2 : w;
        sh   = {2'b00, a} >> s;
        up   = sh[27:20];
        lo   = sh[19:0];
        need = m_first || ((sz > s) && (up != m_last));
        req_valid = 1'b1;
        req_addr  = a;
        req_width = w[1:0];
        req_size  = sz[1:0];
        hold_en   = hold;
        push(1'b1, '0, 1'b0, 1'b0, "R8 R9 take");
        phases = 1;
        if (need) begin
            push(1'b0, {up, 12'h000}, 1'b1, 1'b0, m_first ? "R3 R7 first strobe" : "R4 R5 R7 strobe");
            phases++;
            if (hold) begin
                push(1'b0, {up, 12'h000}, 1'b0, 1'b0, "R6 hold");
                phases++;
            end
            m_last  = up;
            m_first = 1'b0;
        end
        push(1'b0, lo, 1'b0, 1'b1, "R2 R4 R9 lower");
        @(posedge clk);
        #1 req_valid = 1'b0;
        repeat (phases - 1) @(posedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        m_first = 1'b1;
        m_last  = '0;
        repeat (2) @(posedge clk);
        #1;
        checks++;
        if (addr_pins !== '0 || ua_strobe !== 1'b0 || lo_ready !== 1'b0 || req_taken !== 1'b0) begin
            fails++;
            $display("FAIL R1: pins/stb/rdy/taken actual %h/%b/%b/%b expected 0/0/0/0",
                     addr_pins, ua_strobe, lo_ready, req_taken);
        end
        rst_n = 1'b1;
        idle(1);
    endtask

    initial begin
        int          lcg;
        logic [29:0] a;
        m_first = 1'b1;
        m_last  = '0;
        idle(1);
        do_reset();
        issue(30'h0123_4567, 2, 0, 1'b1);   // R3: first access, tiny channel
        issue(30'h0123_4567, 2, 0, 1'b1);   // R4: same upper, skipped
        issue(30'h2F00_0000, 2, 0, 1'b1);   // R4: differs but channel too small
        issue(30'h2F00_0000, 2, 3, 1'b1);   // R4: large channel, differs
        issue(30'h2F00_0010, 2, 3, 1'b1);   // R4: same upper, skipped
        issue(30'h0AB1_2345, 0, 1, 1'b0);   // R6: no hold, 8-bit 2 MB
        issue(30'h0CD1_2345, 0, 0, 1'b0);   // R4: 8-bit 1 MB skipped
        issue(30'h0551_2345, 1, 1, 1'b1);   // R4: 16-bit 2 MB skipped
        issue(30'h0551_2345, 1, 2, 1'b1);   // R5: last value not taken by skip
        issue(30'h1FFF_FFFF, 3, 3, 1'b1);   // R2: code 3 aligns as 32-bit
        issue(30'h1FFF_FFFF, 2, 3, 1'b1);   // R2: same upper, skipped
        idle(3);
        do_reset();
        issue(30'h1FFF_FFFF, 1, 0, 1'b0);   // R3: first after reset again
        lcg = 12345;
        for (int i = 0; i < 60; i++) begin
            lcg = lcg * 1103515245 + 12345;
            a = lcg[29:0];
            if (i % 3 == 0) a = {a[29:20] ^ 10'h3, a[19:0]};
            issue(a, (lcg >>> 4) & 3, (lcg >>> 8) & 3, lcg[12]);
            if (i % 7 == 0) idle(2);
        end
        idle(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule